// File: doc/BRIEF.md
# Three-Port Latched Bus Exchanger

This block links a single 12-bit bus, A, with two 12-bit banks, B1 and B2. Data from A can be sent to B1, to B2 or to both. Data from either B bank can be returned onto A. Each of the four paths has its own storage latch. A latch passes its input straight through while its enable is high. When the enable drops, the latch keeps the input value it held at the last clock edge. The latches are built as clock-enabled registers with a combinational bypass, so the whole block can be synthesized.

Each port has an input bus and an output bus, plus a drive flag that stands in for a tri-state pad. An active-low enable sets the drive flag for each port. A port that is not driving shows all-zero data and a low drive flag. In the B-to-A direction, a select input picks which bank's latch reaches A. Each bank's output enable decides on its own whether that bank is driven.

The drive flag acts as the valid signal for its port's output bus. There is no ready signal and no back-pressure: a receiver takes the data in any cycle its flag is high. The enables, select, reset and latch enables are plain level inputs. Keeping A from being driven from outside while `a_drv` is high is the system's job.

Top module: `mux_latch_xchg`

## Requirements
- R1: While `rst_n` is low, all three drive flags are low, and in the clock cycle after the reset edge every latch holds zero. After reset, a port that is enabled while its latch enable is low shows 0x000.
- R2: While an A-to-B latch enable is high, the output of that bank follows `a_in` in the same cycle.
- R3: When a latch enable is low, the latch output equals the input value that was present at the last rising clock edge with the enable high. Later changes on the input have no effect.
- R4: The B1 and B2 A-to-B latches are independent. Loading one leaves the other's stored value unchanged.
- R5: Each B-to-A latch, one per bank, is transparent and holds in the same way as in R2 and R3, using its own enable and its own bank input.
- R6: `sel_b2` = 0 routes the B1-to-A latch onto A. `sel_b2` = 1 routes the B2-to-A latch onto A.
- R7: Each output enable is active low. A drive flag is high exactly when reset is released and that port's enable is 0. A port that is not driving shows 0x000 on its output bus.
- R8: `oe_b1_n` and `oe_b2_n` gate their banks independently of each other.
- R9: Disabling a port's output does not change the contents of the latches behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 12 | Data arriving on port A |
| a_out | output | 12 | Data driven onto port A |
| a_drv | output | 1 | Port A drive flag (pad enable) |
| b1_in | input | 12 | Data arriving on bank B1 |
| b1_out | output | 12 | Data driven onto bank B1 |
| b1_drv | output | 1 | Bank B1 drive flag |
| b2_in | input | 12 | Data arriving on bank B2 |
| b2_out | output | 12 | Data driven onto bank B2 |
| b2_drv | output | 1 | Bank B2 drive flag |
| le_a2b1 | input | 1 | Latch enable, A toward B1 |
| le_a2b2 | input | 1 | Latch enable, A toward B2 |
| le_b12a | input | 1 | Latch enable, B1 toward A |
| le_b22a | input | 1 | Latch enable, B2 toward A |
| sel_b2 | input | 1 | 0 picks the B1 path onto A, 1 picks the B2 path |
| oe_a_n | input | 1 | Active-low output enable for A |
| oe_b1_n | input | 1 | Active-low output enable for B1 |
| oe_b2_n | input | 1 | Active-low output enable for B2 |

## Verification
The drive flags, the select and the transparent path through an open latch all act in the same cycle as the stimulus, with no register on the way. A held value depends only on the input at the last rising edge where the enable was high. The bench changes its inputs just after each falling edge and samples all three ports 1 ns later. It updates its own model of the four latches at the rising edge, so every comparison falls in the same half-cycle where the design's combinational outputs have settled.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int XCHG_W = 12;
  localparam int N_BANKS = 2;

  typedef enum logic {
    PICK_B1 = 1'b0,
    PICK_B2 = 1'b1
  } bank_pick_e;
endpackage

// File: rtl/xchg_latch.sv
module xchg_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  held_q <= '0;
    else if (le) held_q <= din;
  end

  // open latch passes input through in the same cycle
  assign dout = le ? din : held_q;

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> (le || $stable(dout)));

  // R3
  capture_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> (le || dout == $past(din)));
endmodule

// File: rtl/xchg_drive.sv
module xchg_drive #(
  parameter int W = 12
) (
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic [W-1:0] val,
  output logic [W-1:0] out,
  output logic         drv
);
  assign drv = rst_n & ~oe_n;
  assign out = drv ? val : '0;
endmodule

// File: rtl/mux_latch_xchg.sv
module mux_latch_xchg
  import xchg_pkg::*;
#(
  parameter int W = XCHG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_drv,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_drv,
  input  logic         le_a2b1,
  input  logic         le_a2b2,
  input  logic         le_b12a,
  input  logic         le_b22a,
  input  logic         sel_b2,
  input  logic         oe_a_n,
  input  logic         oe_b1_n,
  input  logic         oe_b2_n
);
  logic [N_BANKS-1:0] le_out, le_back, oe_bank_n;
  logic [W-1:0]       bank_in   [N_BANKS];
  logic [W-1:0]       out_val   [N_BANKS];
  logic [W-1:0]       back_val  [N_BANKS];
  logic [W-1:0]       bank_out  [N_BANKS];
  logic [N_BANKS-1:0] bank_drv;
  logic [W-1:0]       a_val;
  bank_pick_e         pick;

  assign le_out    = {le_a2b2, le_a2b1};
  assign le_back   = {le_b22a, le_b12a};
  assign oe_bank_n = {oe_b2_n, oe_b1_n};
  assign bank_in[0] = b1_in;
  assign bank_in[1] = b2_in;

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    xchg_latch #(.W(W)) u_out_lat (
      .clk(clk), .rst_n(rst_n), .le(le_out[g]), .din(a_in), .dout(out_val[g]));
    xchg_latch #(.W(W)) u_back_lat (
      .clk(clk), .rst_n(rst_n), .le(le_back[g]), .din(bank_in[g]), .dout(back_val[g]));
    xchg_drive #(.W(W)) u_bank_drv (
      .rst_n(rst_n), .oe_n(oe_bank_n[g]), .val(out_val[g]),
      .out(bank_out[g]), .drv(bank_drv[g]));
  end

  assign pick  = bank_pick_e'(sel_b2);
  assign a_val = (pick == PICK_B2) ? back_val[1] : back_val[0];

  xchg_drive #(.W(W)) u_a_drv (
    .rst_n(rst_n), .oe_n(oe_a_n), .val(a_val), .out(a_out), .drv(a_drv));

  assign b1_out = bank_out[0];
  assign b2_out = bank_out[1];
  assign b1_drv = bank_drv[0];
  assign b2_drv = bank_drv[1];

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!a_drv && !b1_drv && !b2_drv));

  // R6
  pick_b1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drv && !sel_b2) |-> (a_out == back_val[0]));

  // R6
  pick_b2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drv && sel_b2) |-> (a_out == back_val[1]));

  // R8
  bank_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b1_drv == !oe_b1_n) && (b2_drv == !oe_b2_n));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_drv || a_out == a_val) && (a_drv || a_out == '0));
endmodule

// File: tb/sim_mux_latch_xchg.sv
`timescale 1ns/1ps
module sim_mux_latch_xchg;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b1_in, b2_in, a_out, b1_out, b2_out;
  logic a_drv, b1_drv, b2_drv;
  logic le_a2b1, le_a2b2, le_b12a, le_b22a, sel_b2, oe_a_n, oe_b1_n, oe_b2_n;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_a2b1, m_a2b2, m_b12a, m_b22a;

  always #5 clk = ~clk;

  mux_latch_xchg #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b1_in(b1_in), .b1_out(b1_out), .b1_drv(b1_drv),
    .b2_in(b2_in), .b2_out(b2_out), .b2_drv(b2_drv),
    .le_a2b1(le_a2b1), .le_a2b2(le_a2b2), .le_b12a(le_b12a), .le_b22a(le_b22a),
    .sel_b2(sel_b2), .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n));

  // bench model of the four stores, updated from bench stimulus
  always @(posedge clk) begin
    if (!rst_n) begin
      m_a2b1 <= '0; m_a2b2 <= '0; m_b12a <= '0; m_b22a <= '0;
    end else begin
      if (le_a2b1) m_a2b1 <= a_in;
      if (le_a2b2) m_a2b2 <= a_in;
      if (le_b12a) m_b12a <= b1_in;
      if (le_b22a) m_b22a <= b2_in;
    end
  end

  function automatic logic [W-1:0] lat_view(logic le, logic [W-1:0] d, logic [W-1:0] q);
    return le ? d : q;
  endfunction

  task automatic cmp(string tag, string port, logic [W-1:0] act, logic actd,
                     logic [W-1:0] exp, logic expd);
    checks++;
    if (act !== exp || actd !== expd) begin
      errors++;
      $display("FAIL %s port %s: actual data=%h drv=%b expected data=%h drv=%b",
               tag, port, act, actd, exp, expd);
    end
  endtask

  task automatic check_all(string tag);
    logic da, d1, d2;
    logic [W-1:0] va;
    da = rst_n && !oe_a_n;
    d1 = rst_n && !oe_b1_n;
    d2 = rst_n && !oe_b2_n;
    va = sel_b2 ? lat_view(le_b22a, b2_in, m_b22a) : lat_view(le_b12a, b1_in, m_b12a);
    cmp(tag, "A", a_out, a_drv, da ? va : '0, da);
    cmp(tag, "B1", b1_out, b1_drv, d1 ? lat_view(le_a2b1, a_in, m_a2b1) : '0, d1);
    cmp(tag, "B2", b2_out, b2_drv, d2 ? lat_view(le_a2b2, a_in, m_a2b2) : '0, d2);
  endtask

  task automatic settle(string tag);
    #1 check_all(tag);
    @(negedge clk);
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    rst_n = 0; a_in = 12'hFFF; b1_in = 12'hEEE; b2_in = 12'hDDD;
    le_a2b1 = 1; le_a2b2 = 1; le_b12a = 1; le_b22a = 1;
    sel_b2 = 0; oe_a_n = 0; oe_b1_n = 0; oe_b2_n = 0;
    @(negedge clk); @(negedge clk);
    settle("R1 reset flags");
    le_a2b1 = 0; le_a2b2 = 0; le_b12a = 0; le_b22a = 0;
    @(negedge clk);
    rst_n = 1;
    settle("R1 cleared stores");
    sel_b2 = 1;
    settle("R1 cleared B2 store");

    // R2 transparency and R8 bank gating
    oe_b2_n = 1; le_a2b1 = 1; a_in = 12'hABC;
    settle("R2 R8 B1 open");
    le_a2b1 = 0; a_in = 12'h123;
    settle("R3 B1 holds");
    oe_b2_n = 0; oe_b1_n = 1;
    settle("R4 R8 B2 untouched");
    le_a2b2 = 1; a_in = 12'h5A5;
    settle("R2 B2 open");
    le_a2b2 = 0; a_in = 12'h000; oe_b1_n = 0;
    settle("R4 both banks distinct");

    // R5 and R6 return path
    b1_in = 12'h111; b2_in = 12'h222; le_b12a = 1; le_b22a = 1; sel_b2 = 0;
    settle("R5 R6 B1 open onto A");
    sel_b2 = 1;
    settle("R5 R6 B2 open onto A");
    le_b12a = 0; le_b22a = 0; b1_in = 12'h999; b2_in = 12'h888;
    settle("R5 B2 held onto A");
    sel_b2 = 0;
    settle("R6 B1 held onto A");

    // R7 and R9: disabled ports, stores kept
    oe_a_n = 1; oe_b1_n = 1; oe_b2_n = 1; a_in = 12'h777;
    settle("R7 all idle");
    settle("R9 idle hold");
    oe_a_n = 0; oe_b1_n = 0; oe_b2_n = 0;
    settle("R9 stores kept after idle");

    // mixed random traffic
    for (int i = 0; i < 1500; i++) begin
      a_in = W'($urandom()); b1_in = W'($urandom()); b2_in = W'($urandom());
      le_a2b1 = ($urandom_range(3) == 0);
      le_a2b2 = ($urandom_range(3) == 0);
      le_b12a = ($urandom_range(3) == 0);
      le_b22a = ($urandom_range(3) == 0);
      sel_b2  = 1'($urandom_range(1));
      oe_a_n  = ($urandom_range(3) == 0);
      oe_b1_n = ($urandom_range(3) == 0);
      oe_b2_n = ($urandom_range(3) == 0);
      if (i == 700) rst_n = 0;
      if (i == 703) rst_n = 1;
      settle("R2 R3 R5 R6 R7 R8 random");
    end
    finish_up();
  end
endmodule